// File: doc/BRIEF.md
# Vector Loop Sequencer with Data-Dependent Early Exit

This block steps through the elements of a vector operation one at a time. It starts at index 0 and runs up to the vector length supplied at start. Before the run it captures a predicate mask, and elements whose mask bit is clear are passed over without any work. For each active element it raises a ready signal toward an external ALU and takes one result per valid/ready handshake. From that result it forms a four-bit condition field. It then applies a pass/fail test that the run configuration selects.

The test comes in two forms. The condition-bit form picks one bit of the condition field and XORs it with an invert flag. The zero form checks whether the result is non-zero and XORs that with the same flag. An element that passes produces a result-write strobe, and also a condition-field write when the condition-bit form is in use. The first element that fails ends the loop. That element and every later one get no result write. The vector length is then reported truncated: either to the failing index, or to the failing index plus one when the inclusive option is set. The truncated length may be zero, so that later vector operations do nothing.

A run starts only when the two-bit mode field selects fail-first. The saturation codes and the reserved code leave the block idle. The final length and the done pulse are registered.

Top module: `vl_early_exit`

## Requirements
- R1: A start pulse is accepted only while idle and with mode_sel = 2'b01; with mode_sel of 2'b00, 2'b10 or 2'b11 the block stays idle and gives no done pulse, no ALU request and no writes.
- R2: Active elements are requested in strictly ascending index order. alu_ready is high only while an active element is pending, elem_idx shows its index, and exactly one result is consumed per cycle in which alu_valid and alu_ready are both high.
- R3: The condition field on cf_wr_data is bit 3 = lt, bit 2 = gt, bit 1 = eq, bit 0 = so. lt, gt and eq compare the result, taken as signed, against zero, and so is copied from alu_so.
- R4: With test_cr = 1 the element passes when the field bit picked by cond_sel (0 = lt, 1 = gt, 2 = eq, 3 = so), XORed with cond_inv, is 1.
- R5: With test_cr = 0 the element passes when (result non-zero) XOR cond_inv is 1. So cond_inv = 0 fails on a zero result, and cond_inv = 1 fails on a non-zero result.
- R6: A passing element gives a one-cycle wr_en with wr_idx equal to its index, together with cf_wr_en when test_cr = 1.
- R7: At the first failing element the loop ends. No wr_en is issued for that element or for any higher index.
- R8: On a failure at index i, vl_out becomes i when vl_incl = 0 and i+1 when vl_incl = 1. A failure at element 0 with vl_incl = 0 gives vl_out = 0.
- R9: When no element fails, vl_out equals the starting length and done pulses once, after the last element. The length is never reduced for any other reason.
- R10: Elements whose predicate bit is 0 are not requested, not tested and not written, and they cannot end the loop.
- R11: With test_cr = 1 and vl_incl = 1 the failing element's condition field is still written. With vl_incl = 0 it is not.
- R12: After reset, busy, done, wr_en, cf_wr_en and alu_ready are 0 and vl_out is 0.
- R13: A start with vl_in = 0 makes no ALU request, issues no writes, and gives done with vl_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for one loop |
| mode_sel | input | 2 | Mode field; 2'b01 selects fail-first |
| test_cr | input | 1 | 1 = condition-bit test, 0 = zero test |
| cond_sel | input | 2 | Condition-field bit to test |
| cond_inv | input | 1 | Invert the test sense |
| vl_incl | input | 1 | Include the failing element in the truncated length |
| vl_in | input | VL_W | Starting vector length, at most MAXVL |
| pred_mask | input | MAXVL | Predicate mask, bit i enables element i |
| alu_valid | input | 1 | ALU result valid |
| alu_result | input | DATA_W | ALU result for element elem_idx |
| alu_so | input | 1 | Summary-overflow flag for the result |
| alu_ready | output | 1 | Sequencer waits for the current element's result |
| elem_idx | output | IDX_W | Index of the element being requested |
| wr_en | output | 1 | Result register write strobe |
| cf_wr_en | output | 1 | Condition-field write strobe |
| wr_idx | output | IDX_W | Element index for wr_en and cf_wr_en |
| cf_wr_data | output | 4 | Condition field {lt, gt, eq, so} |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle pulse when the loop ends |
| vl_out | output | VL_W | Final, possibly truncated, vector length |

## Verification
Some properties are checked on every cycle. A rejected start with a non-fail-first mode leaves the block idle. Result writes never carry a masked-off index and never coincide with done. Condition-field writes occur only in the condition-bit test form. The element index never moves backwards during a run, and the reported length never exceeds the captured length.

Other properties can only be shown by the bench's scenarios, because they need a reference model: which element fails first, the exact truncation point under the inclusive and exclusive choices, the condition field contents, and the selected bit and inversion. The bench runs directed corners (zero length, failure at element 0, a masked failing value, a full-length run) and randomized runs with random ALU stalls.

// File: rtl/vlee_pkg.sv
package vlee_pkg;

  // condition field, packed so that lt lands in bit 3 and so in bit 0
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cfield_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } seq_st_t;

  localparam logic [1:0] MODE_FFIRST = 2'b01;

  // cond_sel codes
  localparam logic [1:0] SEL_LT = 2'd0;
  localparam logic [1:0] SEL_GT = 2'd1;
  localparam logic [1:0] SEL_EQ = 2'd2;
  localparam logic [1:0] SEL_SO = 2'd3;

endpackage

// File: rtl/vlee_cond_eval.sv
module vlee_cond_eval
  import vlee_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              so_in,
  input  logic              test_cr,
  input  logic [1:0]        sel,
  input  logic              inv,
  output cfield_t           cf,
  output logic              pass
);

  logic is_zero;
  logic picked;

  always_comb begin
    is_zero = (result == '0);
    cf.lt   = result[DATA_W-1];
    cf.eq   = is_zero;
    cf.gt   = !result[DATA_W-1] && !is_zero;
    cf.so   = so_in;

    unique case (sel)
      SEL_LT:  picked = cf.lt;
      SEL_GT:  picked = cf.gt;
      SEL_EQ:  picked = cf.eq;
      default: picked = cf.so;
    endcase

    if (test_cr) pass = picked ^ inv;
    else         pass = (!is_zero) ^ inv;
  end

endmodule

// File: rtl/vlee_elem_seq.sv
module vlee_elem_seq
  import vlee_pkg::*;
#(
  parameter int MAXVL = 32,
  parameter int VL_W  = $clog2(MAXVL + 1),
  parameter int IDX_W = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  input  logic [VL_W-1:0]  vl_in,
  input  logic [MAXVL-1:0] pred_in,
  input  logic             incl_in,
  input  logic             alu_valid,
  input  logic             pass,
  output logic             busy,
  output logic             alu_ready,
  output logic             fire,
  output logic             finish,
  output logic [VL_W-1:0]  idx,
  output logic [VL_W-1:0]  fin_vl,
  output logic [VL_W-1:0]  vl_cap,
  output logic [MAXVL-1:0] pred_cap
);

  seq_st_t          st;
  logic [VL_W-1:0]  idx_q;
  logic [VL_W-1:0]  vl_q;
  logic [MAXVL-1:0] pred_q;
  logic             incl_q;
  logic             at_end;
  logic             lane_on;
  logic             running;

  always_comb begin
    running   = (st == S_RUN);
    at_end    = (idx_q >= vl_q);
    lane_on   = !at_end && pred_q[idx_q[IDX_W-1:0]];
    alu_ready = running && lane_on;
    fire      = alu_ready && alu_valid;
    finish    = running && (at_end || (fire && !pass));
    if (at_end)      fin_vl = vl_q;
    else if (incl_q) fin_vl = idx_q + VL_W'(1);
    else             fin_vl = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      idx_q  <= '0;
      vl_q   <= '0;
      pred_q <= '0;
      incl_q <= 1'b0;
    end else if (start_ok) begin
      st     <= S_RUN;
      idx_q  <= '0;
      vl_q   <= vl_in;
      pred_q <= pred_in;
      incl_q <= incl_in;
    end else if (running) begin
      if (finish)                st    <= S_IDLE;
      else if (!lane_on || fire) idx_q <= idx_q + VL_W'(1);
    end
  end

  assign busy     = running;
  assign idx      = idx_q;
  assign vl_cap   = vl_q;
  assign pred_cap = pred_q;

  // R2
  idx_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (idx_q >= $past(idx_q)));

  // R8
  fin_bound_chk: assert property (@(posedge clk) disable iff (rst)
    finish |-> (fin_vl <= vl_q));

endmodule

// File: rtl/vl_early_exit.sv
module vl_early_exit
  import vlee_pkg::*;
#(
  parameter int MAXVL  = 32,
  parameter int DATA_W = 32,
  parameter int VL_W   = $clog2(MAXVL + 1),
  parameter int IDX_W  = $clog2(MAXVL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode_sel,
  input  logic              test_cr,
  input  logic [1:0]        cond_sel,
  input  logic              cond_inv,
  input  logic              vl_incl,
  input  logic [VL_W-1:0]   vl_in,
  input  logic [MAXVL-1:0]  pred_mask,
  input  logic              alu_valid,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_so,
  output logic              alu_ready,
  output logic [IDX_W-1:0]  elem_idx,
  output logic              wr_en,
  output logic              cf_wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [3:0]        cf_wr_data,
  output logic              busy,
  output logic              done,
  output logic [VL_W-1:0]   vl_out
);

  logic             start_ok;
  logic             rc_q;
  logic [1:0]       sel_q;
  logic             inv_q;
  logic             fire;
  logic             finish;
  logic             pass;
  logic [VL_W-1:0]  idx;
  logic [VL_W-1:0]  fin_vl;
  logic [VL_W-1:0]  vl_cap;
  logic [MAXVL-1:0] pred_cap;
  cfield_t          cf;

  assign start_ok = start && !busy && (mode_sel == MODE_FFIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_q  <= 1'b0;
      sel_q <= '0;
      inv_q <= 1'b0;
    end else if (start_ok) begin
      rc_q  <= test_cr;
      sel_q <= cond_sel;
      inv_q <= cond_inv;
    end
  end

  vlee_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .result  (alu_result),
    .so_in   (alu_so),
    .test_cr (rc_q),
    .sel     (sel_q),
    .inv     (inv_q),
    .cf      (cf),
    .pass    (pass)
  );

  vlee_elem_seq #(.MAXVL(MAXVL), .VL_W(VL_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_ok  (start_ok),
    .vl_in     (vl_in),
    .pred_in   (pred_mask),
    .incl_in   (vl_incl),
    .alu_valid (alu_valid),
    .pass      (pass),
    .busy      (busy),
    .alu_ready (alu_ready),
    .fire      (fire),
    .finish    (finish),
    .idx       (idx),
    .fin_vl    (fin_vl),
    .vl_cap    (vl_cap),
    .pred_cap  (pred_cap)
  );

  assign elem_idx = idx[IDX_W-1:0];

  logic             incl_run;
  always_ff @(posedge clk) begin
    if (rst)           incl_run <= 1'b0;
    else if (start_ok) incl_run <= vl_incl;
  end

  // registered write and completion outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en      <= 1'b0;
      cf_wr_en   <= 1'b0;
      wr_idx     <= '0;
      cf_wr_data <= '0;
      done       <= 1'b0;
      vl_out     <= '0;
    end else begin
      wr_en      <= fire && pass;
      cf_wr_en   <= fire && rc_q && (pass || incl_run);
      wr_idx     <= idx[IDX_W-1:0];
      cf_wr_data <= cf;
      done       <= finish;
      if (finish) vl_out <= fin_vl;
    end
  end

  // R1
  bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && mode_sel != MODE_FFIRST) |=> !busy);

  // R7
  done_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

  // R10
  pred_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> pred_cap[wr_idx]);

  // R11
  cf_rc_chk: assert property (@(posedge clk) disable iff (rst)
    cf_wr_en |-> rc_q);

  // R8
  vl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (vl_out <= vl_cap));

endmodule

// File: tb/vl_early_exit_tb.sv
module vl_early_exit_tb;

  localparam int MAXVL  = 32;
  localparam int DATA_W = 32;
  localparam int VL_W   = $clog2(MAXVL + 1);
  localparam int IDX_W  = $clog2(MAXVL);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [1:0]        mode_sel = 2'b00;
  logic              test_cr = 1'b0;
  logic [1:0]        cond_sel = 2'd0;
  logic              cond_inv = 1'b0;
  logic              vl_incl = 1'b0;
  logic [VL_W-1:0]   vl_in = '0;
  logic [MAXVL-1:0]  pred_mask = '0;
  logic              alu_valid = 1'b0;
  logic [DATA_W-1:0] alu_result;
  logic              alu_so;
  logic              alu_ready;
  logic [IDX_W-1:0]  elem_idx;
  logic              wr_en;
  logic              cf_wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [3:0]        cf_wr_data;
  logic              busy;
  logic              done;
  logic [VL_W-1:0]   vl_out;

  always #2 clk = ~clk;

  vl_early_exit #(.MAXVL(MAXVL), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
    .test_cr(test_cr), .cond_sel(cond_sel), .cond_inv(cond_inv),
    .vl_incl(vl_incl), .vl_in(vl_in), .pred_mask(pred_mask),
    .alu_valid(alu_valid), .alu_result(alu_result), .alu_so(alu_so),
    .alu_ready(alu_ready), .elem_idx(elem_idx), .wr_en(wr_en),
    .cf_wr_en(cf_wr_en), .wr_idx(wr_idx), .cf_wr_data(cf_wr_data),
    .busy(busy), .done(done), .vl_out(vl_out)
  );

  logic [DATA_W-1:0] res_mem [MAXVL];
  logic              so_mem  [MAXVL];
  assign alu_result = res_mem[elem_idx];
  assign alu_so     = so_mem[elem_idx];

  int n_tests = 0;
  int n_fail  = 0;
  int viol    = 0;
  int done_cnt = 0;
  int ready_cnt = 0;
  int last_wr = -1;
  logic [MAXVL-1:0]   cur_pred = '0;
  logic [MAXVL-1:0]   got_wr, got_cfen, ewr, ecfen;
  logic [4*MAXVL-1:0] got_cf, ecf;
  int evl;

  // monitor and ALU stall driver, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (int'(wr_idx) <= last_wr) viol++;
        last_wr = int'(wr_idx);
        got_wr[wr_idx] = 1'b1;
      end
      if (cf_wr_en) begin
        got_cfen[wr_idx] = 1'b1;
        got_cf[4*wr_idx +: 4] = cf_wr_data;
      end
      if (alu_ready) begin
        ready_cnt++;
        if (!cur_pred[elem_idx]) viol++;
      end
      if (done) done_cnt++;
    end
    alu_valid <= ($urandom_range(0, 3) != 0);
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] mk_cf(input logic [DATA_W-1:0] r, input logic s);
    logic lt, eq, gt;
    lt = r[DATA_W-1];
    eq = (r == 0);
    gt = !lt && !eq;
    return {lt, gt, eq, s};
  endfunction

  function automatic logic elem_pass(input logic [3:0] f, input logic [DATA_W-1:0] r,
                                     input logic rc, input logic [1:0] sel, input logic iv);
    if (rc) return f[3 - sel] ^ iv;   // sel 0 -> lt (bit 3) ... 3 -> so (bit 0)
    return (r != 0) ^ iv;
  endfunction

  task automatic fill_rand();
    for (int i = 0; i < MAXVL; i++) begin
      res_mem[i] = ($urandom_range(0, 5) == 0) ? '0 : DATA_W'($urandom);
      so_mem[i]  = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic run_case(input logic rc, input logic [1:0] sel, input logic iv,
                          input logic inc, input int vl, input logic [MAXVL-1:0] pm,
                          input string tag);
    logic [3:0] f;
    int wait_cyc;
    ewr = '0; ecfen = '0; ecf = '0; evl = vl;
    for (int i = 0; i < vl; i++) begin
      if (!pm[i]) continue;
      f = mk_cf(res_mem[i], so_mem[i]);
      if (elem_pass(f, res_mem[i], rc, sel, iv)) begin
        ewr[i] = 1'b1;
        if (rc) begin ecfen[i] = 1'b1; ecf[4*i +: 4] = f; end
      end else begin
        if (rc && inc) begin ecfen[i] = 1'b1; ecf[4*i +: 4] = f; end
        evl = inc ? i + 1 : i;
        break;
      end
    end
    @(negedge clk);
    got_wr = '0; got_cfen = '0; got_cf = '0;
    viol = 0; done_cnt = 0; ready_cnt = 0; last_wr = -1; cur_pred = pm;
    mode_sel = 2'b01; test_cr = rc; cond_sel = sel; cond_inv = iv;
    vl_incl = inc; vl_in = VL_W'(vl); pred_mask = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_cyc = 0;
    while (done_cnt == 0 && wait_cyc < 2000) begin
      @(negedge clk);
      wait_cyc++;
    end
    @(negedge clk);
    check(done_cnt == 1, "R9", {tag, " done pulses"}, 128'(done_cnt), 128'(1));
    check(got_wr == ewr, "R7", {tag, " write mask (R6)"}, 128'(got_wr), 128'(ewr));
    check(got_cfen == ecfen, "R11", {tag, " cf write mask (R6)"}, 128'(got_cfen), 128'(ecfen));
    check(got_cf == ecf, "R3", {tag, " cf data"}, 128'(got_cf), 128'(ecf));
    check(int'(vl_out) == evl, "R8", {tag, " final vl"}, 128'(vl_out), 128'(evl));
    check(viol == 0, "R2", {tag, " order/predicate (R10)"}, 128'(viol), 128'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    fill_rand();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check({busy, done, wr_en, cf_wr_en, alu_ready} == 5'b0, "R12", "control outputs",
          128'({busy, done, wr_en, cf_wr_en, alu_ready}), 128'(0));
    check(vl_out == '0, "R12", "vl_out", 128'(vl_out), 128'(0));

    // R1 non fail-first modes are ignored
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      done_cnt = 0; ready_cnt = 0; got_wr = '0;
      mode_sel = 2'(m); vl_in = VL_W'(8); pred_mask = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      check(!busy && done_cnt == 0 && ready_cnt == 0 && got_wr == '0, "R1", "mode ignored",
            128'({busy, 8'(done_cnt), 8'(ready_cnt)}), 128'(0));
    end

    // R9 no failure keeps vl
    for (int i = 0; i < MAXVL; i++) res_mem[i] = DATA_W'(i + 5);
    run_case(1'b1, 2'd2, 1'b1, 1'b0, 20, '1, "R9 all pass");
    // full length
    run_case(1'b0, 2'd0, 1'b0, 1'b1, MAXVL, '1, "R9 full length");
    // R13 zero length
    run_case(1'b1, 2'd0, 1'b0, 1'b0, 0, '1, "R13 zero vl");
    // R8 element 0 fails, exclusive -> 0
    res_mem[0] = '0;
    run_case(1'b0, 2'd0, 1'b0, 1'b0, 10, '1, "R8 elem0 excl");
    // R11 element 0 fails, inclusive, cf written
    run_case(1'b1, 2'd2, 1'b1, 1'b1, 10, '1, "R11 elem0 incl");
    run_case(1'b1, 2'd2, 1'b1, 1'b0, 10, '1, "R11 elem0 excl");
    // R10 masked failing element is skipped
    res_mem[0] = 32'd9; res_mem[3] = '0;
    run_case(1'b0, 2'd0, 1'b0, 1'b0, 12, ~(MAXVL'(1) << 3), "R10 masked zero");
    run_case(1'b0, 2'd0, 1'b0, 1'b0, 12, '1, "R5 unmasked zero");
    // R4 so-bit select
    for (int i = 0; i < MAXVL; i++) so_mem[i] = 1'b1;
    so_mem[5] = 1'b0;
    run_case(1'b1, 2'd3, 1'b0, 1'b1, 16, '1, "R4 so select");
    // R4 lt select with negative value
    res_mem[7] = 32'hffff_fff0;
    run_case(1'b1, 2'd0, 1'b1, 1'b0, 16, '1, "R4 lt inverted");
    run_case(1'b1, 2'd1, 1'b0, 1'b1, 16, '1, "R4 gt select");
    // R5 inverted zero test fails on non-zero
    run_case(1'b0, 2'd0, 1'b1, 1'b1, 16, '1, "R5 inverted");

    for (int k = 0; k < 250; k++) begin
      fill_rand();
      run_case(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), $urandom_range(0, MAXVL), MAXVL'($urandom),
               "random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule